// File: doc/BRIEF.md
# Rising-Edge Digital Phase Aligner

This block sits inside a distributed clock-alignment loop. It receives two divided clocks of equal frequency, a reference and a feedback, and samples both with a fast system clock. It compares only their rising edges, decides whether the feedback edge came early or late, and steps a tap-select counter. The counter picks one of a bank of equally spaced phase taps that arrive as an input vector, and that tap becomes the output clock. The rest of the loop is a fixed delay, so moving the output phase moves the feedback edge. After each step the block discards a set number of edge pairs, which gives the correction time to travel around the loop.

A lock flag reports when decisions have settled into alternation around the target phase. An error flag reports when lock has not arrived within a configurable cycle budget. A bypass control sends the undelayed source clock to the output and freezes the loop.

Top module: `phase_aligner`

## Requirements
- R1: After reset, tap_idx is 0, locked is 0, lock_err is 0, and out_clk follows taps[0].
- R2: When a feedback rising edge precedes the reference rising edge of the same pair (early), tap_idx increments by one, and N_TAPS-1 wraps to 0.
- R3: When a feedback rising edge follows the reference rising edge (late), tap_idx decrements by one, and 0 wraps to N_TAPS-1.
- R4: When both rising edges are seen in the same system-clock cycle (aligned), tap_idx does not change.
- R5: Falling edges of either input have no effect. The order and spacing of the falls do not change any decision.
- R6: After a step, the next WAIT_PAIRS edge pairs are discarded. They change neither tap_idx nor the lock state. Aligned decisions do not start such a wait.
- R7: While both inputs stay low, tap_idx holds its value indefinitely.
- R8: While bypass is 1, out_clk equals src_clk, tap_idx is frozen, and no edge pair is counted.
- R9: While bypass is 0, out_clk equals taps[tap_idx].
- R10: locked rises after LOCK_ALT consecutive counted decisions that are balanced. A balanced decision is aligned, or is an early or late that differs from the previous directional decision since the last aligned one.
- R11: locked falls once UNLOCK_SAME consecutive decisions go in the same direction.
- R12: lock_err sets after TIMEOUT_CYC consecutive unlocked cycles and stays set until reset.
- R13: tap_idx never moves by more than one position (modulo N_TAPS) from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk | input | 1 | Divided reference clock |
| fb_clk | input | 1 | Divided feedback clock |
| src_clk | input | 1 | Undelayed source clock for bypass |
| taps | input | N_TAPS | Equally spaced phase taps |
| bypass | input | 1 | Route src_clk to out_clk and freeze the loop |
| out_clk | output | 1 | Selected output clock |
| tap_idx | output | $clog2(N_TAPS) | Current tap selection |
| locked | output | 1 | Loop settled |
| lock_err | output | 1 | Lock timeout, sticky |

## Verification
The hardest condition to reach from the ports is losing lock. It needs a long history: a full run of balanced decisions first, and then same-direction decisions, each separated by the discarded pairs that follow a step. The bench builds this history with a scripted series of edge pairs that have controlled early, late or zero offsets and varied falling-edge order. An arithmetic model of the tap, the discard counter and the run counters predicts every pair's outcome. Wraparound is reached by walking the tap index around the full ring in both directions.

// File: rtl/pa_pkg.sv
package pa_pkg;
   typedef enum logic [1:0] {
      DEC_NONE  = 2'd0,
      DEC_EARLY = 2'd1,
      DEC_LATE  = 2'd2,
      DEC_ALIGN = 2'd3
   } pa_dec_t;

   typedef enum logic [1:0] {
      PJ_IDLE = 2'd0,
      PJ_REF  = 2'd1,
      PJ_FB   = 2'd2
   } pa_pair_st_t;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial assert (STAGES >= 2) else $error("pa_sync: STAGES must be at least 2");

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pa_pair_judge.sv
module pa_pair_judge
   import pa_pkg::*;
#(
   parameter int WAIT_PAIRS  = 2,
   parameter int SYNC_STAGES = 2,
   localparam int WAIT_W = (WAIT_PAIRS > 0) ? $clog2(WAIT_PAIRS + 1) : 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    ref_in,
   input  logic    fb_in,
   input  logic    bypass,
   output pa_dec_t dec
);
   logic [1:0] raw, synced, prev, rise;
   pa_pair_st_t st, st_n;
   logic skip, skip_n, skip_now, done;
   logic [WAIT_W-1:0] hold, hold_n;
   pa_dec_t kind;

   assign raw = {fb_in, ref_in};

   for (genvar g = 0; g < 2; g++) begin : g_sync
      pa_sync #(.STAGES(SYNC_STAGES)) sync_i (
         .clk(clk), .rst_n(rst_n), .d(raw[g]), .q(synced[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= '0;
      else        prev <= synced;
   end

   assign rise = synced & ~prev;

   always_comb begin
      st_n     = st;
      skip_n   = skip;
      hold_n   = hold;
      skip_now = skip;
      done     = 1'b0;
      kind     = DEC_NONE;
      dec      = DEC_NONE;
      if (bypass) begin
         st_n = PJ_IDLE;
      end else begin
         case (st)
            PJ_IDLE: begin
               if (rise[0] && rise[1]) begin
                  done     = 1'b1;
                  kind     = DEC_ALIGN;
                  skip_now = (hold != '0);
               end else if (rise[0]) begin
                  st_n   = PJ_REF;
                  skip_n = (hold != '0);
               end else if (rise[1]) begin
                  st_n   = PJ_FB;
                  skip_n = (hold != '0);
               end
            end
            PJ_REF: if (rise[1]) begin
               done = 1'b1;
               kind = DEC_LATE;
               st_n = PJ_IDLE;
            end
            PJ_FB: if (rise[0]) begin
               done = 1'b1;
               kind = DEC_EARLY;
               st_n = PJ_IDLE;
            end
            default: st_n = PJ_IDLE;
         endcase
         if (done) begin
            if (skip_now) begin
               hold_n = hold - 1'b1;
            end else begin
               dec = kind;
               if (kind != DEC_ALIGN) hold_n = WAIT_W'(WAIT_PAIRS);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= PJ_IDLE;
         skip <= 1'b0;
         hold <= '0;
      end else begin
         st   <= st_n;
         skip <= skip_n;
         hold <= hold_n;
      end
   end
endmodule

// File: rtl/pa_tap_ctrl.sv
module pa_tap_ctrl
   import pa_pkg::*;
#(
   parameter int N_TAPS = 16,
   localparam int TAP_W = $clog2(N_TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pa_dec_t          dec,
   output logic [TAP_W-1:0] tap
);
   logic [TAP_W-1:0] up, dn;

   if ((N_TAPS & (N_TAPS - 1)) == 0) begin : g_pow2
      assign up = tap + 1'b1;
      assign dn = tap - 1'b1;
   end else begin : g_mod
      assign up = (tap == TAP_W'(N_TAPS - 1)) ? '0 : tap + 1'b1;
      assign dn = (tap == '0) ? TAP_W'(N_TAPS - 1) : tap - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 tap <= '0;
      else if (dec == DEC_EARLY)  tap <= up;
      else if (dec == DEC_LATE)   tap <= dn;
   end
endmodule

// File: rtl/pa_lock_mon.sv
module pa_lock_mon
   import pa_pkg::*;
#(
   parameter int LOCK_ALT    = 8,
   parameter int UNLOCK_SAME = 3,
   parameter int TIMEOUT_CYC = 100000,
   localparam int ALT_W  = $clog2(LOCK_ALT + 1),
   localparam int SAME_W = $clog2(UNLOCK_SAME + 1),
   localparam int TO_W   = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic    clk,
   input  logic    rst_n,
   input  pa_dec_t dec,
   output logic    locked,
   output logic    lock_err
);
   logic [ALT_W-1:0]  alt, alt_n;
   logic [SAME_W-1:0] same, same_n;
   pa_dec_t           last, last_n;
   logic              locked_n;
   logic [TO_W-1:0]   to_cnt;

   always_comb begin
      alt_n  = alt;
      same_n = same;
      last_n = last;
      if (dec == DEC_ALIGN) begin
         alt_n  = (alt == ALT_W'(LOCK_ALT)) ? alt : alt + 1'b1;
         same_n = '0;
         last_n = DEC_NONE;
      end else if (dec != DEC_NONE) begin
         last_n = dec;
         if (dec == last) begin
            same_n = (same == SAME_W'(UNLOCK_SAME)) ? same : same + 1'b1;
            alt_n  = ALT_W'(1);
         end else begin
            same_n = SAME_W'(1);
            alt_n  = (alt == ALT_W'(LOCK_ALT)) ? alt : alt + 1'b1;
         end
      end
      locked_n = locked;
      if (alt_n == ALT_W'(LOCK_ALT))          locked_n = 1'b1;
      else if (same_n == SAME_W'(UNLOCK_SAME)) locked_n = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alt      <= '0;
         same     <= '0;
         last     <= DEC_NONE;
         locked   <= 1'b0;
         to_cnt   <= '0;
         lock_err <= 1'b0;
      end else begin
         alt    <= alt_n;
         same   <= same_n;
         last   <= last_n;
         locked <= locked_n;
         if (locked) begin
            to_cnt <= '0;
         end else if (!lock_err) begin
            to_cnt <= to_cnt + 1'b1;
            if (to_cnt == TO_W'(TIMEOUT_CYC - 1)) lock_err <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/phase_aligner.sv
module phase_aligner
   import pa_pkg::*;
#(
   parameter int N_TAPS      = 16,
   parameter int WAIT_PAIRS  = 2,
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_ALT    = 8,
   parameter int UNLOCK_SAME = 3,
   parameter int TIMEOUT_CYC = 100000,
   localparam int TAP_W = $clog2(N_TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_clk,
   input  logic              fb_clk,
   input  logic              src_clk,
   input  logic [N_TAPS-1:0] taps,
   input  logic              bypass,
   output logic              out_clk,
   output logic [TAP_W-1:0]  tap_idx,
   output logic              locked,
   output logic              lock_err
);
   pa_dec_t dec;

   initial begin
      assert (N_TAPS >= 2)      else $error("phase_aligner: N_TAPS must be at least 2");
      assert (LOCK_ALT >= 2)    else $error("phase_aligner: LOCK_ALT must be at least 2");
      assert (UNLOCK_SAME >= 1) else $error("phase_aligner: UNLOCK_SAME must be at least 1");
      assert (TIMEOUT_CYC >= 2) else $error("phase_aligner: TIMEOUT_CYC must be at least 2");
      assert (WAIT_PAIRS >= 0)  else $error("phase_aligner: WAIT_PAIRS must not be negative");
   end

   pa_pair_judge #(.WAIT_PAIRS(WAIT_PAIRS), .SYNC_STAGES(SYNC_STAGES)) judge_i (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_clk), .fb_in(fb_clk),
      .bypass(bypass), .dec(dec)
   );

   pa_tap_ctrl #(.N_TAPS(N_TAPS)) tap_i (
      .clk(clk), .rst_n(rst_n), .dec(dec), .tap(tap_idx)
   );

   pa_lock_mon #(.LOCK_ALT(LOCK_ALT), .UNLOCK_SAME(UNLOCK_SAME),
                 .TIMEOUT_CYC(TIMEOUT_CYC)) lock_i (
      .clk(clk), .rst_n(rst_n), .dec(dec), .locked(locked), .lock_err(lock_err)
   );

   assign out_clk = bypass ? src_clk : taps[tap_idx];
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
   parameter int N_TAPS = 16,
   localparam int TAP_W = $clog2(N_TAPS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_clk,
   input logic             fb_clk,
   input logic             bypass,
   input logic [TAP_W-1:0] tap_idx,
   input logic             lock_err
);
   function automatic logic [TAP_W-1:0] nxt(input logic [TAP_W-1:0] t);
      return (t == TAP_W'(N_TAPS - 1)) ? '0 : t + 1'b1;
   endfunction
   function automatic logic [TAP_W-1:0] prv(input logic [TAP_W-1:0] t);
      return (t == '0) ? TAP_W'(N_TAPS - 1) : t - 1'b1;
   endfunction

   assert_single_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_idx != $past(tap_idx)) |->
         (tap_idx == nxt($past(tap_idx)) || tap_idx == prv($past(tap_idx))));

   assert_bypass_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> $stable(tap_idx));

   assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err |=> lock_err);

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_clk && !fb_clk && !$past(ref_clk) && !$past(fb_clk) &&
       !$past(ref_clk, 2) && !$past(fb_clk, 2)) |=> $stable(tap_idx));
endmodule

bind phase_aligner pa_checker #(.N_TAPS(N_TAPS)) chk_i (
   .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .fb_clk(fb_clk),
   .bypass(bypass), .tap_idx(tap_idx), .lock_err(lock_err)
);

// File: tb/phase_aligner_tb.sv
module phase_aligner_tb_top;
   localparam int N      = 8;
   localparam int WAITP  = 2;
   localparam int LOCKA  = 8;
   localparam int UNLK   = 3;
   localparam int TMO    = 600;
   localparam int TW     = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_clk = 1'b0, fb_clk = 1'b0, src_clk = 1'b0, bypass = 1'b0;
   logic [N-1:0] taps = 8'b1011_0010;
   logic out_clk, locked, lock_err;
   logic [TW-1:0] tap_idx;

   int checks = 0, errors = 0;
   bit done = 0;

   int m_tap = 0, m_hold = 0, m_last = 0, m_alt = 0, m_same = 0;
   bit m_lk = 0;

   always #5 clk = ~clk;

   phase_aligner #(.N_TAPS(N), .WAIT_PAIRS(WAITP), .SYNC_STAGES(2),
                   .LOCK_ALT(LOCKA), .UNLOCK_SAME(UNLK), .TIMEOUT_CYC(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .fb_clk(fb_clk),
      .src_clk(src_clk), .taps(taps), .bypass(bypass), .out_clk(out_clk),
      .tap_idx(tap_idx), .locked(locked), .lock_err(lock_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ref_clk = 0; fb_clk = 0; bypass = 0;
      cyc(4);
      rst_n = 1'b1;
      m_tap = 0; m_hold = 0; m_last = 0; m_alt = 0; m_same = 0; m_lk = 0;
   endtask

   // model of one counted decision: d 1 early, 2 late, 3 aligned
   task automatic model_dec(input int d);
      if (d == 3) begin
         m_alt = (m_alt < LOCKA) ? m_alt + 1 : m_alt; m_same = 0; m_last = 0;
      end else begin
         if (d == m_last) begin
            m_same = (m_same < UNLK) ? m_same + 1 : m_same; m_alt = 1;
         end else begin
            m_same = 1; m_alt = (m_alt < LOCKA) ? m_alt + 1 : m_alt;
         end
         m_last = d;
         m_tap = (d == 1) ? (m_tap + 1) % N : (m_tap + N - 1) % N;
         m_hold = WAITP;
      end
      if (m_alt == LOCKA) m_lk = 1;
      else if (m_same == UNLK) m_lk = 0;
   endtask

   // delta > 0: fb rises delta cycles after ref (late); < 0: before (early)
   task automatic do_pair(input string req, input int delta, input bit fb_falls_first,
                          input bit counted);
      cyc(3);
      if (delta >= 0) begin
         ref_clk = 1; cyc(delta); fb_clk = 1;
      end else begin
         fb_clk = 1; cyc(-delta); ref_clk = 1;
      end
      cyc(4);
      if (fb_falls_first) begin fb_clk = 0; cyc(3); ref_clk = 0; end
      else                begin ref_clk = 0; cyc(3); fb_clk = 0; end
      cyc(8);
      if (counted) begin
         if (m_hold > 0) m_hold--;
         else model_dec(delta == 0 ? 3 : (delta < 0 ? 1 : 2));
      end
      chk(req, tap_idx, m_tap);
      chk("R10/R11 locked", locked, m_lk);
   endtask

   initial begin
      cyc(200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired (all requirements) actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      cyc(1);
      // R1
      chk("R1 tap", tap_idx, 0);
      chk("R1 locked", locked, 0);
      chk("R1 err", lock_err, 0);
      chk("R1 out_clk", out_clk, taps[0]);

      // R7 and R12: inputs tied low
      cyc(TMO - 12);
      chk("R7 tap holds while idle", tap_idx, 0);
      chk("R12 no early error", lock_err, 0);
      cyc(20);
      chk("R12 error set", lock_err, 1);
      cyc(50);
      chk("R12 error sticky", lock_err, 1);

      do_reset();
      // R3 wrap down, R6 discards, R2 wrap up
      do_pair("R3 late wraps 0 to N-1", 3, 0, 1);
      do_pair("R6 discarded pair", -2, 1, 1);
      do_pair("R6 discarded pair", 2, 0, 1);
      do_pair("R2 early wraps N-1 to 0", -1, 0, 1);
      // R2/R5: walk the ring upward with varied fall order
      for (int k = 0; k < N; k++) begin
         do_pair("R6 discard", 0, k[0], 1);
         do_pair("R6 discard", 1, ~k[0], 1);
         do_pair("R2/R5 early step", -(k % 3) - 1, k[1], 1);
      end
      // R3: walk the ring downward
      for (int k = 0; k < N; k++) begin
         do_pair("R6 discard", 0, 0, 1);
         do_pair("R6 discard", 0, 1, 1);
         do_pair("R3/R5 late step", (k % 3) + 1, k[0], 1);
      end
      do_pair("R6 discard", 0, 0, 1);
      do_pair("R6 discard", 0, 0, 1);
      do_pair("R4 aligned no step", 0, 1, 1);
      do_pair("R4 aligned no wait", 0, 0, 1);

      // R10 lock, R11 unlock
      do_reset();
      for (int i = 0; i < LOCKA; i++) begin
         do_pair("R10 alternating step", (i % 2 == 0) ? -2 : 2, i[0], 1);
         do_pair("R6 discard", 0, 0, 1);
         do_pair("R6 discard", 0, 1, 1);
      end
      chk("R10 locked after run", locked, 1);
      for (int i = 0; i < UNLK; i++) begin
         do_pair("R11 same direction", -1, 0, 1);
         do_pair("R6 discard", 0, 0, 1);
         do_pair("R6 discard", 0, 0, 1);
      end
      chk("R11 unlocked", locked, 0);

      // R8 bypass
      bypass = 1; src_clk = 1;
      cyc(1);
      chk("R8 out follows src high", out_clk, 1);
      src_clk = 0;
      cyc(1);
      chk("R8 out follows src low", out_clk, 0);
      do_pair("R8 frozen early", -2, 0, 0);
      do_pair("R8 frozen late", 2, 1, 0);
      do_pair("R8 frozen aligned", 0, 0, 0);
      bypass = 0;
      cyc(2);
      // R9 tap mux with two patterns
      chk("R9 out tap", out_clk, taps[m_tap]);
      taps = ~taps;
      cyc(1);
      chk("R9 out tap inverted", out_clk, taps[m_tap]);
      do_pair("R8 no pair counted in bypass", 3, 0, 1);
      chk("R9 out after step", out_clk, taps[m_tap]);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule